// File: doc/BRIEF.md
# Control Register with Processor and Clock Watchdogs

This block is a single byte-wide read/write control register on a simple processor bus (address, write strobe, write data, combinational read data). Its bits enable two watchdog timers that run on the PLL clock, select a parallel-access mode flag, and steer a serial message channel transmit path.

The processor watchdog counts PLL cycles while enabled and emits a one-cycle reset pulse when its interval elapses, then starts counting again. The clock-presence watchdog counts PLL cycles while enabled. Its enable bit reads back as 1 until the interval has elapsed and as 0 after that. Both timers are restarted only by a write that takes their enable bit from 0 to 1. Each such edge crosses into the PLL domain as a toggle through a two-flop synchronizer.

On the message channel, one bit selects whether transmit data reaches the bus output directly or through a flop clocked by the message channel clock. Another bit deasserts the output enable and loops transmit data back to the local receive output, so the channel can be tested without driving the shared bus.

Top module: `ctlreg_dualwd`

## Requirements
- R1: After reset the register reads 0x00, `par_access_en_o` is 0, `mc_bus_oe_o` is 1, transmit data passes straight through, and `wd_reset_o` stays low.
- R2: A write with `bus_we` high and `bus_addr` equal to `REG_ADDR` stores bits 0, 1, 2, 4 and 5. Bits 3, 6 and 7 always read as 0. A write to any other address changes nothing, and a read at any other address returns 0x00.
- R3: Bit 0 drives `par_access_en_o` directly.
- R4: With bit 1 set, `wd_reset_o` pulses high for one PLL cycle about `CPU_WD_CYCLES` PLL cycles after the enable, and then again every `CPU_WD_CYCLES` cycles.
- R5: With bit 1 clear, the processor watchdog holds its count and emits no pulse.
- R6: A write that takes bit 1 from 0 to 1 restarts the processor count. Writing 1 to bit 1 while it is already 1 does not restart the count.
- R7: With bit 2 set, bit 2 reads as 1 until about `CLK_WD_CYCLES` PLL cycles have passed, and as 0 from then on.
- R8: A write that takes bit 2 from 0 to 1 re-arms the clock watchdog. Bit 2 reads as 1 from the next read, even if the previous interval had expired, and the full interval runs again.
- R9: With bit 2 clear, bit 2 reads as 0.
- R10: With bit 4 set, `mc_bus_o` takes `mc_txd_i` only at a rising edge of `mc_clk` and holds it between edges. With bit 4 clear, `mc_bus_o` follows `mc_txd_i` with no clock.
- R11: With bit 5 set, `mc_bus_oe_o` is 0 and `mc_rxd_o` equals `mc_txd_i`, and `mc_rxd_i` has no effect. With bit 5 clear, `mc_bus_oe_o` is 1 and `mc_rxd_o` equals `mc_rxd_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bus_clk | input | 1 | Processor bus clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously in each domain |
| bus_addr | input | ADDR_W | Bus address |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from `bus_addr` |
| pll_clk | input | 1 | PLL clock that drives both watchdogs |
| wd_reset_o | output | 1 | One-PLL-cycle device reset pulse from the processor watchdog |
| par_access_en_o | output | 1 | Parallel access mode enable (bit 0) |
| mc_clk | input | 1 | Message channel clock |
| mc_txd_i | input | 1 | Local transmit data |
| mc_rxd_i | input | 1 | Receive data from the shared bus pad |
| mc_bus_o | output | 1 | Transmit data toward the shared bus pad |
| mc_bus_oe_o | output | 1 | Output enable for the shared bus pad |
| mc_rxd_o | output | 1 | Receive data to local logic, or the loopback |

## Verification
Each watchdog is tried with a plain enable, with a 0-then-1 rewrite in the middle of the interval, and with a redundant rewrite of 1. Pulse counts taken just before and after the expected deadline tell a real restart from an ignored one. The clock watchdog is also read back right after a re-arm that follows an expiry, which tells whether a stale expired flag leaks into the readback. The message channel is driven with transmit changes placed between clock edges and then at edges, and with the receive input moved while loopback is on. This separates the direct path from the registered path and shows whether loopback really isolates the pad input.

// File: rtl/ctlwd_pkg.sv
package ctlwd_pkg;
  localparam int unsigned REG_W    = 8;
  localparam int unsigned B_PAR    = 0;
  localparam int unsigned B_CPUWD  = 1;
  localparam int unsigned B_CLKWD  = 2;
  localparam int unsigned B_TXREG  = 4;
  localparam int unsigned B_MCOFF  = 5;
  localparam logic [REG_W-1:0] DEF_MASK = 8'h37;

  localparam int unsigned WD_N   = 2;
  localparam int unsigned WD_CPU = 0;
  localparam int unsigned WD_CLK = 1;

  function automatic int unsigned wd_bit(input int unsigned idx);
    return (idx == WD_CPU) ? B_CPUWD : B_CLKWD;
  endfunction
endpackage

// File: rtl/ctlwd_rstn_sync.sv
module ctlwd_rstn_sync (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);
  logic [1:0] stg_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) stg_q <= 2'b00;
    else         stg_q <= {stg_q[0], 1'b1};
  end

  assign rst_n_o = stg_q[1];
endmodule

// File: rtl/ctlwd_sync.sv
module ctlwd_sync #(
  parameter int unsigned W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/ctlwd_timer.sv
module ctlwd_timer #(
  parameter int unsigned LIMIT    = 100,
  parameter bit          PERIODIC = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en_i,
  input  logic arm_i,
  output logic event_o
);
  localparam int unsigned CW = (LIMIT > 2) ? $clog2(LIMIT) : 1;
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          exp_q, exp_d;
  logic          fire_q, fire_d;

  always_comb begin
    cnt_d  = cnt_q;
    exp_d  = exp_q;
    fire_d = 1'b0;
    if (arm_i) begin
      cnt_d = '0;
      exp_d = 1'b0;
    end else if (en_i && !exp_q) begin
      if (cnt_q == LAST) begin
        cnt_d = '0;
        if (PERIODIC) fire_d = 1'b1;
        else          exp_d  = 1'b1;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      exp_q  <= 1'b0;
      fire_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      exp_q  <= exp_d;
      fire_q <= fire_d;
    end
  end

  assign event_o = PERIODIC ? fire_q : exp_q;

  a_r5_hold_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_i && !arm_i) |=> ($stable(cnt_q) && !fire_q));

  a_r8_arm_clears: assert property (@(posedge clk) disable iff (!rst_n)
    arm_i |=> (cnt_q == '0 && !exp_q));

  generate
    if (PERIODIC && LIMIT > 1) begin : g_pulse_chk
      a_r4_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        fire_q |=> !fire_q);
    end
  endgenerate
endmodule

// File: rtl/ctlwd_mcpath.sv
module ctlwd_mcpath (
  input  logic clk,
  input  logic rst_n,
  input  logic reg_en_i,
  input  logic loop_en_i,
  input  logic txd_i,
  input  logic rxd_i,
  output logic bus_o,
  output logic oe_o,
  output logic rxd_o
);
  logic txd_q, txd_d;

  always_comb txd_d = txd_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) txd_q <= 1'b0;
    else        txd_q <= txd_d;
  end

  assign bus_o = reg_en_i  ? txd_q : txd_i;
  assign oe_o  = !loop_en_i;
  assign rxd_o = loop_en_i ? txd_i : rxd_i;

  a_r11_loopback: assert property (@(posedge clk) disable iff (!rst_n)
    loop_en_i |-> (!oe_o && rxd_o == txd_i));
endmodule

// File: rtl/ctlreg_dualwd.sv
module ctlreg_dualwd
  import ctlwd_pkg::*;
#(
  parameter int unsigned       ADDR_W        = 4,
  parameter logic [ADDR_W-1:0] REG_ADDR      = ADDR_W'('hC),
  parameter int unsigned       PLL_HZ        = 32_768_000,
  parameter int unsigned       CPU_WD_CYCLES = PLL_HZ / 1000 * 256,
  parameter int unsigned       CLK_WD_CYCLES = PLL_HZ / 8000
) (
  input  logic              bus_clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [REG_W-1:0]  bus_wdata,
  output logic [REG_W-1:0]  bus_rdata,
  input  logic              pll_clk,
  output logic              wd_reset_o,
  output logic              par_access_en_o,
  input  logic              mc_clk,
  input  logic              mc_txd_i,
  input  logic              mc_rxd_i,
  output logic              mc_bus_o,
  output logic              mc_bus_oe_o,
  output logic              mc_rxd_o
);
  logic bus_rst_n, pll_rst_n, mc_rst_n;

  ctlwd_rstn_sync u_rs_bus (.clk(bus_clk), .arst_n(rst_n), .rst_n_o(bus_rst_n));
  ctlwd_rstn_sync u_rs_pll (.clk(pll_clk), .arst_n(rst_n), .rst_n_o(pll_rst_n));
  ctlwd_rstn_sync u_rs_mc  (.clk(mc_clk),  .arst_n(rst_n), .rst_n_o(mc_rst_n));

  // bus domain: register and re-arm toggles
  logic             wr_hit;
  logic [REG_W-1:0] ctl_q, ctl_d;
  logic [WD_N-1:0]  tog_q, tog_d, rise, en_b;

  assign wr_hit = bus_we && (bus_addr == REG_ADDR);

  generate
    for (genvar i = 0; i < WD_N; i++) begin : g_rise
      assign rise[i] = bus_wdata[wd_bit(i)] && !ctl_q[wd_bit(i)];
      assign en_b[i] = ctl_q[wd_bit(i)];
    end
  endgenerate

  always_comb begin
    ctl_d = bus_wdata & DEF_MASK;
    tog_d = tog_q ^ rise;
  end

  always_ff @(posedge bus_clk or negedge bus_rst_n) begin
    if (!bus_rst_n) begin
      ctl_q <= '0;
      tog_q <= '0;
    end else if (wr_hit) begin
      ctl_q <= ctl_d;
      tog_q <= tog_d;
    end
  end

  // PLL domain: synchronize enables and toggles, run timers
  logic [WD_N-1:0] en_s, tog_s, seen_q, arm, wd_evt;

  ctlwd_sync #(.W(2 * WD_N)) u_to_pll (
    .clk(pll_clk), .rst_n(pll_rst_n),
    .d_i({tog_q, en_b}), .q_o({tog_s, en_s})
  );

  always_ff @(posedge pll_clk or negedge pll_rst_n) begin
    if (!pll_rst_n) seen_q <= '0;
    else            seen_q <= tog_s;
  end

  assign arm = tog_s ^ seen_q;

  generate
    for (genvar i = 0; i < WD_N; i++) begin : g_wd
      ctlwd_timer #(
        .LIMIT   ((i == WD_CPU) ? CPU_WD_CYCLES : CLK_WD_CYCLES),
        .PERIODIC(i == WD_CPU)
      ) u_timer (
        .clk(pll_clk), .rst_n(pll_rst_n),
        .en_i(en_s[i]), .arm_i(arm[i]), .event_o(wd_evt[i])
      );
    end
  endgenerate

  assign wd_reset_o = wd_evt[WD_CPU];

  // back to bus domain: expiry flag and acknowledged toggle
  logic clk_exp_b, seen_b, stale;
  logic [REG_W-1:0] rd_val;

  ctlwd_sync #(.W(2)) u_to_bus (
    .clk(bus_clk), .rst_n(bus_rst_n),
    .d_i({wd_evt[WD_CLK], seen_q[WD_CLK]}), .q_o({clk_exp_b, seen_b})
  );

  assign stale = tog_q[WD_CLK] ^ seen_b;

  always_comb begin
    rd_val          = ctl_q;
    rd_val[B_CLKWD] = ctl_q[B_CLKWD] && (stale || !clk_exp_b);
  end

  assign bus_rdata       = (bus_addr == REG_ADDR) ? rd_val : '0;
  assign par_access_en_o = ctl_q[B_PAR];

  ctlwd_mcpath u_mc (
    .clk(mc_clk), .rst_n(mc_rst_n),
    .reg_en_i(ctl_q[B_TXREG]), .loop_en_i(ctl_q[B_MCOFF]),
    .txd_i(mc_txd_i), .rxd_i(mc_rxd_i),
    .bus_o(mc_bus_o), .oe_o(mc_bus_oe_o), .rxd_o(mc_rxd_o)
  );

  a_r2_other_addr_zero: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
    (bus_addr != REG_ADDR) |-> (bus_rdata == '0));

  a_r2_reserved_zero: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
    (bus_rdata & ~DEF_MASK) == '0);

  a_r9_status_off: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
    !ctl_q[B_CLKWD] |-> !bus_rdata[B_CLKWD]);
endmodule

// File: tb/ctlreg_dualwd_test.sv
`timescale 1ns/1ps
module ctlreg_dualwd_test;
  localparam logic [3:0] RA = 4'hC;
  localparam logic [3:0] RB = 4'hD;

  logic       bus_clk = 1'b0, pll_clk = 1'b0, mc_clk = 1'b0, rst_n = 1'b0;
  logic [3:0] bus_addr = RA;
  logic       bus_we = 1'b0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic       wd_reset_o, par_access_en_o;
  logic       mc_txd_i = 1'b0, mc_rxd_i = 1'b0;
  logic       mc_bus_o, mc_bus_oe_o, mc_rxd_o;

  always #10 bus_clk = ~bus_clk;
  always #4  pll_clk = ~pll_clk;
  always #15 mc_clk  = ~mc_clk;

  ctlreg_dualwd #(
    .ADDR_W(4), .REG_ADDR(RA), .CPU_WD_CYCLES(200), .CLK_WD_CYCLES(100)
  ) uut (
    .bus_clk(bus_clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pll_clk(pll_clk),
    .wd_reset_o(wd_reset_o), .par_access_en_o(par_access_en_o),
    .mc_clk(mc_clk), .mc_txd_i(mc_txd_i), .mc_rxd_i(mc_rxd_i),
    .mc_bus_o(mc_bus_o), .mc_bus_oe_o(mc_bus_oe_o), .mc_rxd_o(mc_rxd_o)
  );

  int n_run = 0, n_fail = 0, pulses = 0;

  typedef struct { logic [7:0] exp; string tag; } item_t;
  item_t sb_q[$];

  always @(negedge pll_clk) if (wd_reset_o === 1'b1) pulses++;

  // monitor: compare read data with the scoreboard
  always @(negedge bus_clk) begin
    item_t it;
    if (sb_q.size() != 0) begin
      it = sb_q.pop_front();
      n_run++;
      if (bus_rdata !== it.exp) begin
        n_fail++;
        $display("FAIL %s: read 0x%02h expected 0x%02h", it.tag, bus_rdata, it.exp);
      end
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(posedge bus_clk); #2;
    bus_addr = a; bus_we = 1'b1; bus_wdata = d;
    @(posedge bus_clk); #2;
    bus_we = 1'b0; bus_addr = RA;
  endtask

  task automatic rd_expect(input logic [3:0] a, input logic [7:0] e, input string tag);
    @(posedge bus_clk); #2;
    bus_addr = a;
    sb_q.push_back('{exp: e, tag: tag});
    @(negedge bus_clk); #1;
    bus_addr = RA;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge bus_clk);
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  initial begin
    #1_000_000;
    n_run++; n_fail++;
    $display("FAIL watchdog: run did not complete");
    finish_run();
  end

  int base;

  initial begin
    repeat (4) @(posedge bus_clk);
    #3 rst_n = 1'b1;
    idle(4);

    // R1 reset state
    rd_expect(RA, 8'h00, "R1 reset readback");
    check("R1 par off", par_access_en_o, 0);
    check("R1 oe on", mc_bus_oe_o, 1);
    mc_txd_i = 1'b1; #1;
    check("R1 passthrough", mc_bus_o, 1);
    mc_txd_i = 1'b0; #1;
    check("R1 passthrough low", mc_bus_o, 0);
    check("R1 no reset pulse", pulses, 0);

    // R2 / R3 register access
    wr(RA, 8'h01);
    rd_expect(RA, 8'h01, "R3 readback");
    check("R3 par on", par_access_en_o, 1);
    rd_expect(RB, 8'h00, "R2 other address read");
    wr(RA, 8'hC8);
    rd_expect(RA, 8'h00, "R2 reserved bits");
    check("R3 par cleared", par_access_en_o, 0);
    wr(RB, 8'h01);
    rd_expect(RA, 8'h00, "R2 write elsewhere ignored");
    check("R2 par unchanged", par_access_en_o, 0);

    // R4 / R5 processor watchdog
    base = pulses;
    wr(RA, 8'h02);
    idle(50);
    check("R4 no pulse early", pulses - base, 0);
    idle(50);
    check("R4 first pulse", pulses - base, 1);
    idle(80);
    check("R4 periodic pulse", pulses - base, 2);
    wr(RA, 8'h00);
    base = pulses;
    idle(250);
    check("R5 no pulse disabled", pulses - base, 0);

    // R6 restart by 0->1, not by 1->1
    base = pulses;
    wr(RA, 8'h02);
    idle(60);
    wr(RA, 8'h00);
    wr(RA, 8'h02);
    idle(36);
    check("R6 restart delays pulse", pulses - base, 0);
    idle(50);
    check("R6 pulse after restart", pulses - base, 1);
    wr(RA, 8'h00);
    base = pulses;
    wr(RA, 8'h02);
    idle(60);
    wr(RA, 8'h02);
    idle(30);
    check("R6 redundant write ignored", pulses - base, 1);
    wr(RA, 8'h00);
    idle(10);

    // R7 / R8 / R9 clock watchdog
    rd_expect(RA, 8'h00, "R9 bit clear when off");
    wr(RA, 8'h04);
    rd_expect(RA, 8'h04, "R7 set right after enable");
    idle(20);
    rd_expect(RA, 8'h04, "R7 set before interval");
    idle(50);
    rd_expect(RA, 8'h00, "R7 clear after interval");
    wr(RA, 8'h00);
    wr(RA, 8'h04);
    rd_expect(RA, 8'h04, "R8 set right after re-arm");
    idle(20);
    rd_expect(RA, 8'h04, "R8 still set mid interval");
    idle(50);
    rd_expect(RA, 8'h00, "R8 clear after new interval");
    wr(RA, 8'h00);
    rd_expect(RA, 8'h00, "R9 clear after disable");

    // R10 registered transmit
    wr(RA, 8'h10);
    @(negedge mc_clk); mc_txd_i = 1'b1; #1;
    check("R10 held between edges", mc_bus_o, 0);
    @(posedge mc_clk); #1;
    check("R10 captured at edge", mc_bus_o, 1);
    @(negedge mc_clk); mc_txd_i = 1'b0; #1;
    check("R10 held high", mc_bus_o, 1);
    @(posedge mc_clk); #1;
    check("R10 captured low", mc_bus_o, 0);
    wr(RA, 8'h00);
    mc_txd_i = 1'b1; #1;
    check("R10 passthrough again", mc_bus_o, 1);

    // R11 output disable with loopback
    wr(RA, 8'h20);
    #1;
    check("R11 oe off", mc_bus_oe_o, 0);
    mc_rxd_i = 1'b0; mc_txd_i = 1'b1; #1;
    check("R11 loop high", mc_rxd_o, 1);
    mc_txd_i = 1'b0; #1;
    check("R11 loop low", mc_rxd_o, 0);
    mc_rxd_i = 1'b1; #1;
    check("R11 pad input ignored", mc_rxd_o, 0);
    wr(RA, 8'h00);
    #1;
    check("R11 oe back on", mc_bus_oe_o, 1);
    check("R11 rxd from pad", mc_rxd_o, 1);

    idle(4);
    finish_run();
  end
endmodule